// File: doc/BRIEF.md
# Pre-Trigger Sample Buffer Controller

This block manages a circular sample store of 2^AW words for an embedded capture instrument. Once armed, it writes the incoming sample word into the store on every sample cycle, wrapping around as needed. A sample cycle is either every clock cycle or only the cycles on which a capture enable is high, as selected by a mode input. The trigger decision is made elsewhere. When the trigger input is seen on a sample cycle, the block records where that sample was written. It then keeps writing until the store holds the requested number of samples from before the trigger, the trigger sample itself, and enough later samples to fill it.

A host reads the result through an index port. Index 0 always returns the oldest kept sample. Index D returns the trigger sample, where D is the programmed pre-trigger count clamped to size minus one. STATUS is high from arming until the store is full. A done flag then stays high until the next arm or flush. Reading is permitted only while STATUS is low. A synchronous flush input, and the asynchronous reset, return the block to idle and empty the store.

Top module: `ptsb_ctrl`

## Requirements
- R1: After rst_n low or a cycle with flush high, status and done are 0 and every rd_idx reads back 0; flush takes priority over all other inputs in its cycle.
- R2: arm high while status is 0 sets status to 1 and done to 0 at the next edge, latches dly, and discards everything stored before, so that entries not rewritten later read as 0.
- R3: With every_edge=1 a sample is taken on every cycle whatever cap_en is; with every_edge=0 a sample is taken only on cycles with cap_en=1, and din on other cycles is never stored.
- R4: trig is acted on only on a sample cycle while waiting for a trigger; trig on non-sample cycles, or after the trigger has been taken, has no effect.
- R5: With effective delay E = min(dly, 2^AW-1), rd_idx = E returns the trigger sample, and rd_idx = i returns the sample taken i-E sample cycles from the trigger sample (chronological order, oldest at index 0).
- R6: A dly of 2^AW-1 or more behaves as 2^AW-1: the trigger sample is read at the last index and nothing follows it.
- R7: Counting the trigger sample, exactly 2^AW-E samples are stored from the trigger on. status falls and done rises at the edge that stores the last of them. Later samples and triggers change nothing until the next arm or flush.
- R8: If fewer than E samples were taken between arming and the trigger, the missing leading indices read as 0.
- R9: rd_en=1 while status is 0 loads rd_data with the word at rd_idx at the next edge; rd_en while status is 1 is ignored and rd_data holds.
- R10: status is 1 exactly while waiting for a trigger or filling after it; done is 1 only after the store has filled; the two are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous flush to idle, empties the store |
| arm | input | 1 | Start a capture (accepted while status is 0) |
| every_edge | input | 1 | 1: sample on every clock; 0: sample when cap_en is 1 |
| cap_en | input | 1 | Capture-clock enable for gated sampling |
| trig | input | 1 | Trigger decision from the trigger logic |
| din | input | DW | Sample word |
| dly | input | DLYW | Requested number of pre-trigger samples |
| rd_en | input | 1 | Readout request |
| rd_idx | input | AW | Chronological readout index |
| rd_data | output | DW | Readout word, valid the cycle after rd_en |
| status | output | 1 | Armed: waiting for trigger or filling |
| done | output | 1 | Store filled since last arm |

## Verification
The hardest condition to reach is a trigger with fewer stored samples ahead of it than the delay asks for, right after an earlier full capture has left stale words in every location. The bench runs a complete capture first. It then re-arms with a large delay and triggers on the fourth sample, so only cleared entries can supply zeros at the head of the readout. Gated captures hold trig high on every non-sample cycle and change din on those cycles, so any sample taken at the wrong time shows up in the readout. The clamp is exercised both at the exact limit and well beyond it.

// File: rtl/ptsb_pkg.sv
package ptsb_pkg;

    // Capture sequence states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // not armed, no finished capture
        ST_WAIT = 2'd1,   // armed, writing, looking for trigger
        ST_POST = 2'd2,   // trigger taken, filling the rest
        ST_DONE = 2'd3    // store full
    } ptsb_state_e;

endpackage

// File: rtl/ptsb_store.sv
// Sample store with one valid bit per word; cleared words read as zero.
module ptsb_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_all,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int SIZE = 1 << AW;

    typedef struct packed {
        logic [SIZE-1:0] vld;
    } store_t;

    store_t d, q;
    logic [DW-1:0] mem [SIZE];

    always_comb begin
        d = q;
        if (clr_all) begin
            d.vld = '0;
        end
        if (wr_en) begin
            d.vld[waddr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{vld: '0};
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = q.vld[raddr] ? mem[raddr] : '0;

endmodule

// File: rtl/ptsb_seq.sv
// Arm / trigger / fill sequencer and write pointer.
module ptsb_seq
    import ptsb_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DLYW = AW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            arm,
    input  logic            smp,
    input  logic            trig,
    input  logic [DLYW-1:0] dly,
    output logic            wr_en,
    output logic [AW-1:0]   waddr,
    output logic            clr_all,
    output logic [AW-1:0]   base,
    output logic            status,
    output logic            done
);
    localparam int SIZE = 1 << AW;
    localparam int LW   = AW + 1;
    localparam logic [DLYW-1:0] MAXD = DLYW'(SIZE - 1);

    typedef struct packed {
        ptsb_state_e   state;
        logic [AW-1:0] wptr;   // next write location
        logic [AW-1:0] taddr;  // location of the trigger sample
        logic [AW-1:0] deff;   // clamped pre-trigger count
        logic [LW-1:0] left;   // samples still to store after trigger
    } seq_t;

    seq_t d, q;
    logic [AW-1:0] deff_in;
    logic [LW-1:0] post_init;

    // Clamp the requested delay to size minus one.
    always_comb begin
        if (dly > MAXD) begin
            deff_in = AW'(SIZE - 1);
        end else begin
            deff_in = dly[AW-1:0];
        end
    end

    // Samples after the trigger sample: SIZE - deff - 1.
    assign post_init = LW'(SIZE) - LW'(q.deff) - LW'(1);

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        clr_all = 1'b0;
        case (q.state)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    d.state = ST_WAIT;
                    d.wptr  = '0;
                    d.taddr = '0;
                    d.deff  = deff_in;
                    d.left  = '0;
                    clr_all = 1'b1;
                end
            end
            ST_WAIT: begin
                if (smp) begin
                    wr_en  = 1'b1;
                    d.wptr = q.wptr + 1'b1;
                    if (trig) begin
                        d.taddr = q.wptr;
                        d.left  = post_init;
                        if (post_init == '0) begin
                            d.state = ST_DONE;
                        end else begin
                            d.state = ST_POST;
                        end
                    end
                end
            end
            ST_POST: begin
                if (smp) begin
                    wr_en  = 1'b1;
                    d.wptr = q.wptr + 1'b1;
                    d.left = q.left - 1'b1;
                    if (q.left == LW'(1)) begin
                        d.state = ST_DONE;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
        if (flush) begin
            d       = '{state: ST_IDLE, wptr: '0, taddr: '0, deff: '0, left: '0};
            wr_en   = 1'b0;
            clr_all = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, wptr: '0, taddr: '0, deff: '0, left: '0};
        end else begin
            q <= d;
        end
    end

    assign waddr  = q.wptr;
    assign base   = q.taddr - q.deff;
    assign status = (q.state == ST_WAIT) || (q.state == ST_POST);
    assign done   = (q.state == ST_DONE);

endmodule

// File: rtl/ptsb_rdport.sv
// Chronological readout: maps index to location and registers the word.
module ptsb_rdport #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    input  logic [AW-1:0] base,
    input  logic          busy,
    output logic [AW-1:0] raddr,
    input  logic [DW-1:0] rword,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] data;
    } rd_t;

    rd_t d, q;

    assign raddr = base + rd_idx;

    always_comb begin
        d = q;
        if (rd_en && !busy) begin
            d.data = rword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{data: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.data;

endmodule

// File: rtl/ptsb_ctrl.sv
// Pre-trigger sample buffer controller, top level.
module ptsb_ctrl #(
    parameter int AW   = 4,
    parameter int DW   = 8,
    parameter int DLYW = AW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            arm,
    input  logic            every_edge,
    input  logic            cap_en,
    input  logic            trig,
    input  logic [DW-1:0]   din,
    input  logic [DLYW-1:0] dly,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            status,
    output logic            done
);
    logic          smp;
    logic          wr_en;
    logic [AW-1:0] waddr;
    logic          clr_all;
    logic [AW-1:0] base;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rword;

    // Sample strobe: every clock, or only when the capture enable is high.
    assign smp = every_edge | cap_en;

    ptsb_seq #(.AW(AW), .DLYW(DLYW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .arm     (arm),
        .smp     (smp),
        .trig    (trig),
        .dly     (dly),
        .wr_en   (wr_en),
        .waddr   (waddr),
        .clr_all (clr_all),
        .base    (base),
        .status  (status),
        .done    (done)
    );

    ptsb_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .waddr   (waddr),
        .wdata   (din),
        .clr_all (clr_all),
        .raddr   (raddr),
        .rdata   (rword)
    );

    ptsb_rdport #(.AW(AW), .DW(DW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .base    (base),
        .busy    (status),
        .raddr   (raddr),
        .rword   (rword),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ptsb_ctrl_chk.sv
module ptsb_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          arm,
    input logic          rd_en,
    input logic          wr_en,
    input logic          status,
    input logic          done,
    input logic [DW-1:0] rd_data
);
    // R10: armed and finished are exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(status && done));

    // R1: flush returns to idle
    p_flush_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!status && !done));

    // R2: accepted arm raises status
    p_arm_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !status && !flush) |=> (status && !done));

    // R3: the store is written only while armed
    p_wr_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> status);

    // R9: readout blocked while armed
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && status) |=> $stable(rd_data));

    // R7: finished capture is held until arm or flush
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm && !flush) |=> done);

endmodule

bind ptsb_ctrl ptsb_ctrl_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .arm     (arm),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .status  (status),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/ptsb_ctrl_tb.sv
module ptsb_ctrl_tb;
    localparam int  AW   = 4;
    localparam int  DW   = 8;
    localparam int  DLYW = AW + 2;
    localparam int  SIZE = 1 << AW;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n, flush, arm, every_edge, cap_en, trig, rd_en;
    logic [DW-1:0]   din, rd_data;
    logic [DLYW-1:0] dly;
    logic [AW-1:0]   rd_idx;
    logic            status, done;

    int n_vec = 0;
    int n_bad = 0;
    int expv [SIZE];
    int slog [256];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptsb_ctrl #(.AW(AW), .DW(DW), .DLYW(DLYW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .arm(arm),
        .every_edge(every_edge), .cap_en(cap_en), .trig(trig), .din(din),
        .dly(dly), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .status(status), .done(done)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", rq, act, exp);
        end
    endtask

    // Monitor: compares each accepted readout one edge after the request.
    always @(posedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            #1;
            check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
        end
    end

    // Driver: issues one read per cycle and queues the expected word.
    task automatic read_out(input string rq);
        for (int i = 0; i < SIZE; i++) begin
            @(negedge clk);
            rd_en  = 1'b1;
            rd_idx = AW'(i);
            exp_q.push_back(DW'(expv[i]));
            tag_q.push_back($sformatf("%s idx %0d", rq, i));
        end
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // One full capture; builds the expected readout from the samples taken.
    task automatic run_cap(input string rq, input int d, input bit every,
                           input int trig_at, input int seed);
        int e, last, t, c;
        bit sampled;
        e = (d > SIZE - 1) ? SIZE - 1 : d;
        last = trig_at + SIZE - e;
        @(negedge clk);
        dly = DLYW'(d); every_edge = every; cap_en = 1'b0; trig = 1'b1;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check({rq, " R2 status after arm"}, 64'(status), 64'd1);
        t = 0; c = 0;
        while (t < last + 3) begin
            check({rq, " R7/R10 status"}, 64'(status), 64'(t < last));
            check({rq, " R7/R10 done"}, 64'(done), 64'(t >= last));
            sampled = every || (c % 3 != 2);
            cap_en  = every ? c[0] : (c % 3 != 2);
            din     = DW'(c * 29 + seed);
            trig    = !sampled || (t >= trig_at);
            if (sampled) begin
                slog[t] = c * 29 + seed;
                t++;
            end
            c++;
            @(negedge clk);
        end
        trig = 1'b0; cap_en = 1'b0;
        for (int i = 0; i < SIZE; i++) begin
            int j;
            j = trig_at - e + i;
            expv[i] = (j < 0) ? 0 : (slog[j] & ((1 << DW) - 1));
        end
        read_out(rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] prev;
        rst_n = 1'b0; flush = 1'b0; arm = 1'b0; every_edge = 1'b1; cap_en = 1'b0;
        trig = 1'b0; din = '0; dly = '0; rd_en = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", 64'(status), 64'd0);
        check("R1 reset done", 64'(done), 64'd0);
        check("R1 reset rd_data", 64'(rd_data), 64'd0);
        for (int i = 0; i < SIZE; i++) expv[i] = 0;
        read_out("R1 reset readout");

        run_cap("R5 d0 every", 0, 1'b1, 20, 3);
        run_cap("R5 d5 every", 5, 1'b1, 30, 11);
        run_cap("R6 d40 clamp", 40, 1'b1, 25, 5);
        run_cap("R8 short pre", 8, 1'b1, 3, 17);
        run_cap("R3/R4 gated d3", 3, 1'b0, 10, 41);
        run_cap("R6 gated d15", 15, 1'b0, 17, 77);

        // R9: readout ignored while armed; R1: flush mid-capture
        @(negedge clk);
        prev = rd_data;
        dly = '0; every_edge = 1'b1; trig = 1'b0; din = 8'hA5; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0; rd_en = 1'b1; rd_idx = AW'(3);
        @(negedge clk);
        @(negedge clk);
        check("R9 rd_data held while armed", 64'(rd_data), 64'(prev));
        check("R9 status armed", 64'(status), 64'd1);
        rd_en = 1'b0; flush = 1'b1; arm = 1'b1; trig = 1'b1;
        @(negedge clk);
        flush = 1'b0; arm = 1'b0; trig = 1'b0;
        check("R1 flush status", 64'(status), 64'd0);
        check("R1 flush done", 64'(done), 64'd0);
        for (int i = 0; i < SIZE; i++) expv[i] = 0;
        read_out("R1 flush readout");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule